// File: doc/BRIEF.md
# Flow-through zero-turnaround synchronous SRAM

This block is a synthesizable single-port synchronous memory with a shared data path. The word is 18 bits, split into two 9-bit byte lanes (8 data bits plus a parity bit each). Any mix of reads and writes can be issued on consecutive active clocks with no idle cycle between them. A read returns its data combinationally during the cycle after its address is captured. A write takes its data one active clock after its address. That data sits in a held-write register and reaches the array on the following active clock. Reads that hit the held write are served from it, merged lane by lane.

Address and control are registered on the rising edge. A load/advance input either starts a new access or steps a two-bit burst counter over the low address bits, in linear or XOR order. Three chip enables must all be asserted to select the device, and a sleep input forces deselection. An active-low clock enable freezes every register. The bidirectional data pins are modelled as separate write-data and read-data ports, plus a drive-enable output that an asynchronous output enable gates.

Top module: `nbl_sram`

## Requirements
- R1: A read whose address is loaded at an active edge presents that word on `rdata_o` during the next cycle, with no further register, and `drive_o` is high in that cycle when `oe_n_i` is low.
- R2: Write data on `wdata_i` is captured at the active edge one active clock after the write's address. Writes and reads can alternate on consecutive active clocks in any order with no idle cycle.
- R3: Byte selects are active low and are sampled with every accepted address phase, including burst advances. `bws_n_i[0]` enables bits 8:0 and `bws_n_i[1]` enables bits 17:9. Unselected lanes keep their old contents.
- R4: A read of an address whose write data was captured at the previous active edge returns the new data in the enabled lanes and the older stored contents in the other lanes.
- R5: A load with `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0 selects the device. Any other combination makes the next cycle a deselect cycle with `drive_o` low.
- R6: `drive_o` is low in every cycle that is the data phase of a write.
- R7: `oe_n_i` high forces `drive_o` low combinationally, without a clock edge.
- R8: `adv_ld_i`=0 loads a new access and `adv_ld_i`=1 advances the current one. Advancing while deselected keeps the device deselected.
- R9: With `burst_mode_i`=0 captured at load, burst addresses run through the low two bits as (start + n) mod 4, and the upper bits are fixed.
- R10: With `burst_mode_i`=1 captured at load, burst addresses use start XOR n for n = 0..3. The mode given during advances is ignored.
- R11: While `cken_n_i` is high, no state changes and all other inputs are ignored. `rdata_o` and the access in progress persist.
- R12: `sleep_i` high at an active edge makes the next cycle a deselect cycle. The data phase of a write already issued still completes.
- R13: While `rst_ni` is low, `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cken_n_i | input | 1 | Clock enable, active low; high freezes all state |
| addr_i | input | ADDR_W | Word address |
| we_n_i | input | 1 | Write select, active low (high = read) |
| bws_n_i | input | NB | Byte lane write selects, active low |
| ce1_n_i | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_n_i | input | 1 | Chip enable, active low |
| adv_ld_i | input | 1 | 0 = load new access, 1 = advance burst |
| burst_mode_i | input | 1 | 0 = linear burst, 1 = XOR burst |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Forces deselection at the next active edge |
| wdata_i | input | NB*LANE_W | Write data |
| rdata_o | output | NB*LANE_W | Read data |
| drive_o | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is a read that hits a word still sitting in the held-write register under a partial byte mask. Only then does the merge combine new lanes from the register with old lanes from the array. The stimulus writes the full word first, then issues a one-lane write immediately followed by a read of the same address. The new data is on the bus in the same cycle that the read address is loaded, so the check falls in the only cycle where the array is still stale. A clock-enable stall that carries a write request over a live read shows that the frozen request never lands.

// File: rtl/nbl_sram_pkg.sv
package nbl_sram_pkg;
  localparam int unsigned BURST_W = 2;

  typedef enum logic {
    BURST_LINEAR = 1'b0,
    BURST_XOR    = 1'b1
  } burst_order_e;

  function automatic logic [BURST_W-1:0] burst_step(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] cnt,
    input burst_order_e       ord
  );
    logic [BURST_W-1:0] r;
    if (ord == BURST_XOR) r = start ^ cnt;
    else                  r = start + cnt;
    return r;
  endfunction
endpackage

// File: rtl/nbl_ctrl.sv
module nbl_ctrl
  import nbl_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NB     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_n_i,
  input  logic [NB-1:0]     bws_n_i,
  input  logic              sel_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic              sleep_i,
  output logic              cur_valid_o,
  output logic              cur_write_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [NB-1:0]     cur_be_o
);
  logic               valid_q, write_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  burst_order_e       ord_q;
  logic [NB-1:0]      be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      ord_q   <= BURST_LINEAR;
      be_q    <= '0;
    end else if (en_i) begin
      if (sleep_i) begin
        valid_q <= 1'b0;
      end else if (!adv_i) begin
        valid_q <= sel_i;
        write_q <= ~we_n_i;
        base_q  <= addr_i;
        cnt_q   <= '0;
        ord_q   <= burst_order_e'(mode_i);
        be_q    <= ~bws_n_i;
      end else if (valid_q) begin
        // burst advance keeps op type and order, resamples byte selects
        cnt_q <= cnt_q + BURST_W'(1);
        be_q  <= ~bws_n_i;
      end
    end
  end

  assign cur_valid_o = valid_q;
  assign cur_write_o = write_q;
  assign cur_be_o    = be_q;
  assign cur_addr_o  = {base_q[ADDR_W-1:BURST_W],
                        burst_step(base_q[BURST_W-1:0], cnt_q, ord_q)};
endmodule

// File: rtl/nbl_wr_hold.sv
module nbl_wr_hold #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NB     = 2,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [NB-1:0]     cap_be_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              pend_valid_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [NB-1:0]     pend_be_o,
  output logic [DATA_W-1:0] pend_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_o <= 1'b0;
      pend_addr_o  <= '0;
      pend_be_o    <= '0;
      pend_data_o  <= '0;
    end else if (en_i) begin
      pend_valid_o <= cap_i;
      if (cap_i) begin
        pend_addr_o <= cap_addr_i;
        pend_be_o   <= cap_be_i;
        pend_data_o <= cap_data_i;
      end
    end
  end
endmodule

// File: rtl/nbl_array.sv
module nbl_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned NB     = 2
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [NB-1:0]        wbe_i,
  input  logic [NB*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  output logic [NB*LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/nbl_sram.sv
module nbl_sram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned NB     = 2,
  localparam int unsigned DATA_W = NB * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cken_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_n_i,
  input  logic [NB-1:0]     bws_n_i,
  input  logic              ce1_n_i,
  input  logic              ce2_i,
  input  logic              ce3_n_i,
  input  logic              adv_ld_i,
  input  logic              burst_mode_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              en, sel;
  logic              cur_valid, cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [NB-1:0]     cur_be;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [NB-1:0]     pend_be;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] arr_rdata;
  logic              hit;

  assign en  = ~cken_n_i;
  assign sel = ~ce1_n_i & ce2_i & ~ce3_n_i;

  nbl_ctrl #(.ADDR_W(ADDR_W), .NB(NB)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .addr_i      (addr_i),
    .we_n_i      (we_n_i),
    .bws_n_i     (bws_n_i),
    .sel_i       (sel),
    .adv_i       (adv_ld_i),
    .mode_i      (burst_mode_i),
    .sleep_i     (sleep_i),
    .cur_valid_o (cur_valid),
    .cur_write_o (cur_write),
    .cur_addr_o  (cur_addr),
    .cur_be_o    (cur_be)
  );

  nbl_wr_hold #(.ADDR_W(ADDR_W), .NB(NB), .DATA_W(DATA_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .cap_i        (cur_valid & cur_write),
    .cap_addr_i   (cur_addr),
    .cap_be_i     (cur_be),
    .cap_data_i   (wdata_i),
    .pend_valid_o (pend_valid),
    .pend_addr_o  (pend_addr),
    .pend_be_o    (pend_be),
    .pend_data_o  (pend_data)
  );

  nbl_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NB(NB)) u_array (
    .clk_i   (clk_i),
    .we_i    (en & pend_valid),
    .waddr_i (pend_addr),
    .wbe_i   (pend_be),
    .wdata_i (pend_data),
    .raddr_i (cur_addr),
    .rdata_o (arr_rdata)
  );

  // coherency: held write overrides array per enabled lane
  assign hit = pend_valid && (pend_addr == cur_addr);

  for (genvar g = 0; g < NB; g++) begin : g_merge
    assign rdata_o[g*LANE_W +: LANE_W] = (hit && pend_be[g]) ? pend_data[g*LANE_W +: LANE_W]
                                                             : arr_rdata[g*LANE_W +: LANE_W];
  end

  assign drive_o = cur_valid & ~cur_write & ~oe_n_i;
endmodule

// File: rtl/nbl_sram_chk.sv
module nbl_sram_chk #(
  parameter int unsigned DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cken_n_i,
  input logic              we_n_i,
  input logic              ce1_n_i,
  input logic              ce2_i,
  input logic              ce3_n_i,
  input logic              adv_ld_i,
  input logic              oe_n_i,
  input logic              sleep_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              drive_o
);
  logic sel_c;
  assign sel_c = ~ce1_n_i & ce2_i & ~ce3_n_i;

  assert_read_drive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cken_n_i && !adv_ld_i && sel_c && we_n_i && !sleep_i) |=> (drive_o != oe_n_i));

  assert_desel_hiz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cken_n_i && !adv_ld_i && !sel_c) |=> !drive_o);

  assert_wr_turnoff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cken_n_i && !adv_ld_i && sel_c && !we_n_i) |=> !drive_o);

  assert_oe_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !drive_o);

  assert_stall_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cken_n_i |=> $stable(rdata_o));

  assert_sleep_desel_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cken_n_i && sleep_i) |=> !drive_o);

  assert_reset_quiet_R13: assert property (@(posedge clk_i)
    !rst_ni |-> !drive_o);
endmodule

bind nbl_sram nbl_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cken_n_i (cken_n_i),
  .we_n_i   (we_n_i),
  .ce1_n_i  (ce1_n_i),
  .ce2_i    (ce2_i),
  .ce3_n_i  (ce3_n_i),
  .adv_ld_i (adv_ld_i),
  .oe_n_i   (oe_n_i),
  .sleep_i  (sleep_i),
  .rdata_o  (rdata_o),
  .drive_o  (drive_o)
);

// File: tb/nbl_sram_tb.sv
module nbl_sram_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni, cken_n_i, we_n_i, ce1_n_i, ce2_i, ce3_n_i;
  logic        adv_ld_i, burst_mode_i, oe_n_i, sleep_i;
  logic [7:0]  addr_i;
  logic [1:0]  bws_n_i;
  logic [17:0] wdata_i, rdata_o;
  logic        drive_o;
  int          checks = 0;
  int          errors = 0;

  always #10 clk_i = ~clk_i;

  nbl_sram u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cken_n_i(cken_n_i), .addr_i(addr_i),
    .we_n_i(we_n_i), .bws_n_i(bws_n_i), .ce1_n_i(ce1_n_i), .ce2_i(ce2_i),
    .ce3_n_i(ce3_n_i), .adv_ld_i(adv_ld_i), .burst_mode_i(burst_mode_i),
    .oe_n_i(oe_n_i), .sleep_i(sleep_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  localparam logic [17:0] DA  = 18'h1A5C3;
  localparam logic [17:0] DB  = 18'h2B6D4;
  localparam logic [17:0] DC  = 18'h0F0E1;
  localparam logic [17:0] DE  = 18'h3C0DE;
  localparam logic [17:0] D0  = 18'h11111;
  localparam logic [17:0] D1  = 18'h22222;
  localparam logic [17:0] D2  = 18'h33333;
  localparam logic [17:0] D3  = 18'h04444;
  localparam logic [17:0] MRG = {DA[17:9], DC[8:0]};

  typedef struct packed {
    logic        adv;
    logic        we_n;
    logic        sel;
    logic        mode;
    logic [1:0]  bws_n;
    logic [7:0]  addr;
    logic [17:0] wd;
    logic        edrv;
    logic [17:0] erd;
  } vec_t;

  // each row: pins for one cycle and the outputs expected in that cycle
  localparam vec_t VEC [24] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h10, 18'h0, 1'b0, 18'h0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h11, DA,    1'b0, 18'h0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'h11, DB,    1'b0, 18'h0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'h10, 18'h0, 1'b1, DB},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 8'h10, 18'h0, 1'b1, DA},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h10, DC,    1'b0, 18'h0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'h00, 18'h0, 1'b1, MRG},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'h00, 18'h0, 1'b0, 18'h0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h21, 18'h0, 1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 8'h00, D0,    1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 8'h00, D1,    1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 8'h00, D2,    1'b0, 18'h0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'h22, D3,    1'b0, 18'h0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'h00, 18'h0, 1'b1, D1},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'h00, 18'h0, 1'b1, D2},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 8'h00, 18'h0, 1'b1, D3},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 8'h00, 18'h0, 1'b1, D0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 8'h00, 18'h0, 1'b0, 18'h0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 8'h23, 18'h0, 1'b0, 18'h0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 8'h00, 18'h0, 1'b1, D2},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 8'h00, 18'h0, 1'b1, D1},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 8'h00, 18'h0, 1'b1, D0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'h00, 18'h0, 1'b1, D3},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'h00, 18'h0, 1'b0, 18'h0}
  };

  function automatic string row_tag(int i);
    case (i)
      3:                 return "R4";
      4:                 return "R2";
      6:                 return "R3";
      7, 8, 17, 18, 23:  return "R5";
      13, 14, 15, 16:    return "R9";
      19, 20, 21, 22:    return "R10";
      default:           return "R6";
    endcase
  endfunction

  task automatic chk_drv(input string tag, input logic exp);
    checks++;
    if (drive_o !== exp) begin
      errors++;
      $display("FAIL %s drive_o actual=%0b expected=%0b t=%0t", tag, drive_o, exp, $time);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [17:0] exp);
    checks++;
    if (rdata_o !== exp) begin
      errors++;
      $display("FAIL %s rdata_o actual=%h expected=%h t=%0t", tag, rdata_o, exp, $time);
    end
  endtask

  task automatic apply(input logic adv, input logic we_n, input logic sel, input logic mode,
                       input logic [1:0] bws, input logic [7:0] addr, input logic [17:0] wd);
    @(negedge clk_i);
    adv_ld_i     = adv;
    we_n_i       = we_n;
    ce1_n_i      = ~sel;
    ce2_i        = sel;
    ce3_n_i      = ~sel;
    burst_mode_i = mode;
    bws_n_i      = bws;
    addr_i       = addr;
    wdata_i      = wd;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b1; cken_n_i = 1'b0; oe_n_i = 1'b0; sleep_i = 1'b0;
    adv_ld_i = 1'b0; we_n_i = 1'b1; ce1_n_i = 1'b1; ce2_i = 1'b0; ce3_n_i = 1'b1;
    burst_mode_i = 1'b0; bws_n_i = 2'b11; addr_i = '0; wdata_i = '0;
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    #5 chk_drv("R13", 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 24; i++) begin
      apply(VEC[i].adv, VEC[i].we_n, VEC[i].sel, VEC[i].mode, VEC[i].bws_n, VEC[i].addr, VEC[i].wd);
      #5;
      chk_drv(row_tag(i), VEC[i].edrv);
      if (VEC[i].edrv) chk_rd(row_tag(i), VEC[i].erd);
    end

    // R11: stall holds a live read while a write request is presented
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h10, 18'h0);
    #5 chk_drv("R5", 1'b0);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h10, DE);
    cken_n_i = 1'b1;
    #5 chk_rd("R11", MRG); chk_drv("R11", 1'b1);
    for (int k = 0; k < 2; k++) begin
      apply(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h10, DE);
      #5 chk_rd("R11", MRG); chk_drv("R11", 1'b1);
    end
    apply(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'h00, 18'h0);
    cken_n_i = 1'b0;
    #5 chk_rd("R11", MRG); chk_drv("R11", 1'b1);

    // R8: advance while deselected stays deselected
    apply(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 8'h00, 18'h0);
    #5 chk_drv("R5", 1'b0);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h10, 18'h0);
    #5 chk_drv("R8", 1'b0);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h11, 18'h0);
    #5 chk_rd("R11", MRG); chk_drv("R1", 1'b1);

    // R7: asynchronous output enable
    apply(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'h00, 18'h0);
    #5 chk_rd("R1", DB); chk_drv("R1", 1'b1);
    oe_n_i = 1'b1;
    #1 chk_drv("R7", 1'b0);
    oe_n_i = 1'b0;
    #1 chk_drv("R7", 1'b1);

    // R12: sleep deselects but a write's data phase completes
    apply(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'h30, 18'h0);
    #5 chk_drv("R6", 1'b0);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h11, DE);
    sleep_i = 1'b1;
    #5 chk_drv("R6", 1'b0);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 8'h30, 18'h0);
    sleep_i = 1'b0;
    #5 chk_drv("R12", 1'b0);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 8'h00, 18'h0);
    #5 chk_rd("R12", DE); chk_drv("R12", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule